// File: doc/BRIEF.md
# Interrupt Error Status Logic

This block collects the error conditions of a local interrupt controller and presents them to software through an eight-bit error status register (ESR). Error events come from three places. Writes to the local vector table entries can carry a reserved vector. An access can target an offset where no register exists. Strobes from the inter-processor message path report checksum, accept and outgoing-vector faults. Each event sets a bit in a hidden sticky latch, which software cannot read.

Software makes the gathered errors visible by writing the ESR. Each such write copies the hidden latch into the ESR and starts a new gathering period. The written data is ignored. A separate error entry holds an interrupt vector and a mask bit. While that entry is unmasked, every newly gathered error bit raises a one-cycle interrupt request that carries the entry's vector.

The register port is a plain word-addressed read/write interface with combinational read data. The layout is as follows:
- Offset 0 is the ESR.
- Offset 1 is the error entry.
- Offsets 2 to 2+NUM_LVT-1 are the other vector table entries.
- Every remaining offset is unmapped.

Top module: `intr_err_status`

## Requirements
- R1: After reset the ESR reads 0, the hidden latch is empty, the error entry reads 0x0001_0000 (mask bit 16 set, vector 0), every vector table entry reads 0x0001_0000, and no interrupt request is raised.
- R2: Any write to offset 0 loads the ESR with the bits gathered since the previous such write, and the write data is ignored. The ESR does not change at any other time.
- R3: A second ESR write with no error gathered in between makes the ESR read 0.
- R4: The ESR bit map is: bit 0 is the send checksum error (bus_err[0]), bit 1 the receive checksum error (bus_err[1]), bit 2 the send accept error (bus_err[2]), bit 3 the receive accept error (bus_err[3]), and bit 5 the send illegal vector error (send_vec_err).
- R5: A write to a vector table entry whose delivery mode field (bits 10:8) is 000 and whose vector (bits 7:0) is below 16 sets ESR bit 6, whether or not the mask bit 16 is set. Other modes and vectors from 16 upward set nothing.
- R6: A write to the error entry (offset 1) with a vector below 16 sets ESR bit 6, because that entry always uses fixed delivery.
- R7: A read or write to an unmapped offset sets ESR bit 7, and such a read returns 0.
- R8: ESR bit 4 always reads 0.
- R9: Gathered errors stay invisible in the ESR until the next ESR write.
- R10: While the error entry's mask is 0, any cycle that gathers a bit not already held in the latch raises err_irq for exactly the next cycle, with err_irq_vec equal to the entry's vector. A masked entry, or a bit that is already held, raises nothing.
- R11: An error that arrives in the same cycle as an ESR write is not put into that snapshot. It goes into the new gathering period and appears after the following ESR write.
- R12: A vector table entry reads back its vector in bits 7:0, its mode in bits 10:8 and its mask in bit 16, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| bus_err | input | 4 | Message path strobes: send checksum, receive checksum, send accept, receive accept |
| send_vec_err | input | 1 | Outgoing message used an illegal vector |
| err_irq | output | 1 | One-cycle error interrupt request |
| err_irq_vec | output | 8 | Vector carried with the request |

## Verification
Because the latch is hidden, a wrong gathering state shows up at the ports only after a later ESR write and read. A bit dropped or invented by the latch therefore appears one snapshot late, as a wrong ESR value. The bench compares the ESR value produced by each stimulus in isolation, so every such fault is tied to the action that caused it. A faulty newness test or a faulty mask gate shows up at once, in err_irq one cycle after the event. The collision of an error with an ESR write is tested directly, because a wrong choice there loses a bit for good.

// File: rtl/intr_err_pkg.sv
package intr_err_pkg;

  localparam int DATA_W = 32;
  localparam int ESR_W  = 8;

  // ESR bit positions (software visible)
  localparam int B_TX_CKSUM = 0;
  localparam int B_RX_CKSUM = 1;
  localparam int B_TX_ACC   = 2;
  localparam int B_RX_ACC   = 3;
  localparam int B_TX_VEC   = 5;
  localparam int B_RX_VEC   = 6;
  localparam int B_BAD_ADDR = 7;

  localparam logic [2:0] MODE_FIXED = 3'b000;

  typedef struct packed {
    logic       mask;
    logic [2:0] mode;
    logic [7:0] vec;
  } vt_entry_t;

  localparam vt_entry_t VT_RESET = '{mask: 1'b1, mode: 3'b000, vec: 8'h00};

  // Reserved vectors 0..15 are illegal under fixed delivery.
  function automatic logic vec_is_illegal(input logic [2:0] mode, input logic [7:0] vec);
    return (mode == MODE_FIXED) && (vec < 8'd16);
  endfunction

  function automatic vt_entry_t vt_unpack(input logic [DATA_W-1:0] w);
    vt_entry_t e;
    e.mask = w[16];
    e.mode = w[10:8];
    e.vec  = w[7:0];
    return e;
  endfunction

  function automatic logic [DATA_W-1:0] vt_pack(input vt_entry_t e);
    return {15'b0, e.mask, 5'b0, e.mode, e.vec};
  endfunction

endpackage

// File: rtl/intr_err_decode.sv
module intr_err_decode #(
  parameter int ADDR_W  = 4,
  parameter int NUM_LVT = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic               rd,
  output logic               esr_hit,
  output logic               ent_hit,
  output logic [NUM_LVT-1:0] lvt_hit,
  output logic               esr_wr,
  output logic               ent_wr,
  output logic               bad_access
);
  localparam int LVT_BASE = 2;

  assign esr_hit = (addr == ADDR_W'(0));
  assign ent_hit = (addr == ADDR_W'(1));

  for (genvar i = 0; i < NUM_LVT; i++) begin : g_hit
    assign lvt_hit[i] = (addr == ADDR_W'(LVT_BASE + i));
  end

  assign esr_wr     = wr & esr_hit;
  assign ent_wr     = wr & ent_hit;
  assign bad_access = (wr | rd) & ~(esr_hit | ent_hit | (|lvt_hit));
endmodule

// File: rtl/intr_err_vt_bank.sv
module intr_err_vt_bank
  import intr_err_pkg::*;
#(
  parameter int NUM_LVT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVT-1:0] wr_sel,
  input  logic [NUM_LVT-1:0] rd_sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rd_word,
  output logic               wr_illegal
);
  vt_entry_t ent_q [NUM_LVT];

  for (genvar i = 0; i < NUM_LVT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)         ent_q[i] <= VT_RESET;
      else if (wr_sel[i]) ent_q[i] <= vt_unpack(wdata);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_LVT; i++)
      if (rd_sel[i]) rd_word = rd_word | vt_pack(ent_q[i]);
  end

  // Checked regardless of the mask bit being written.
  assign wr_illegal = (|wr_sel) & vec_is_illegal(wdata[10:8], wdata[7:0]);
endmodule

// File: rtl/intr_err_gather.sv
module intr_err_gather
  import intr_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              esr_wr,
  input  logic              ent_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ESR_W-1:0]  incoming,
  output logic [ESR_W-1:0]  esr_q,
  output logic [ESR_W-1:0]  hidden_q,
  output logic [ESR_W-1:0]  new_bits,
  output logic              ent_mask,
  output logic [7:0]        ent_vec,
  output logic              irq,
  output logic [7:0]        irq_vec
);
  logic [ESR_W-1:0] base;
  logic             fire;

  // An ESR write opens a fresh period; same-cycle events land in it.
  assign base     = esr_wr ? '0 : hidden_q;
  assign new_bits = incoming & ~base;
  assign fire     = (|new_bits) & ~ent_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hidden_q <= '0;
      esr_q    <= '0;
      ent_mask <= 1'b1;
      ent_vec  <= 8'h00;
      irq      <= 1'b0;
      irq_vec  <= 8'h00;
    end else begin
      hidden_q <= base | incoming;
      if (esr_wr) esr_q <= hidden_q;
      if (ent_wr) begin
        ent_mask <= wdata[16];
        ent_vec  <= wdata[7:0];
      end
      irq <= fire;
      if (fire) irq_vec <= ent_vec;
    end
  end
endmodule

// File: rtl/intr_err_status.sv
module intr_err_status
  import intr_err_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_LVT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [3:0]        bus_err,
  input  logic              send_vec_err,
  output logic              err_irq,
  output logic [7:0]        err_irq_vec
);
  logic               esr_hit, ent_hit, esr_wr, ent_wr, bad_access;
  logic [NUM_LVT-1:0] lvt_hit;
  logic [31:0]        bank_word;
  logic               lvt_illegal, ent_illegal;
  logic [ESR_W-1:0]   incoming, esr_q, hidden_q, new_bits;
  logic               ent_mask;
  logic [7:0]         ent_vec;

  intr_err_decode #(.ADDR_W(ADDR_W), .NUM_LVT(NUM_LVT)) u_dec (
    .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .esr_hit(esr_hit), .ent_hit(ent_hit), .lvt_hit(lvt_hit),
    .esr_wr(esr_wr), .ent_wr(ent_wr), .bad_access(bad_access)
  );

  intr_err_vt_bank #(.NUM_LVT(NUM_LVT)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_sel(lvt_hit & {NUM_LVT{reg_wr}}),
    .rd_sel(lvt_hit & {NUM_LVT{reg_rd}}),
    .wdata(reg_wdata), .rd_word(bank_word), .wr_illegal(lvt_illegal)
  );

  // The error entry always delivers fixed.
  assign ent_illegal = ent_wr & vec_is_illegal(MODE_FIXED, reg_wdata[7:0]);

  always_comb begin
    incoming             = '0;
    incoming[B_TX_CKSUM] = bus_err[0];
    incoming[B_RX_CKSUM] = bus_err[1];
    incoming[B_TX_ACC]   = bus_err[2];
    incoming[B_RX_ACC]   = bus_err[3];
    incoming[B_TX_VEC]   = send_vec_err;
    incoming[B_RX_VEC]   = lvt_illegal | ent_illegal;
    incoming[B_BAD_ADDR] = bad_access;
  end

  intr_err_gather u_gat (
    .clk(clk), .rst_n(rst_n), .esr_wr(esr_wr), .ent_wr(ent_wr),
    .wdata(reg_wdata), .incoming(incoming),
    .esr_q(esr_q), .hidden_q(hidden_q), .new_bits(new_bits),
    .ent_mask(ent_mask), .ent_vec(ent_vec),
    .irq(err_irq), .irq_vec(err_irq_vec)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (esr_hit)      reg_rdata = {24'b0, esr_q};
      else if (ent_hit) reg_rdata = {15'b0, ent_mask, 8'b0, ent_vec};
      else              reg_rdata = bank_word;
    end
  end
endmodule

// File: rtl/intr_err_status_checker.sv
module intr_err_status_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        esr_wr,
  input logic [7:0]  incoming,
  input logic [7:0]  hidden_q,
  input logic [7:0]  esr_q,
  input logic [7:0]  new_bits,
  input logic        ent_mask,
  input logic        err_irq,
  input logic        reg_rd,
  input logic        bad_access,
  input logic [31:0] reg_rdata
);
  a_r2_esr_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !esr_wr |=> $stable(esr_q));

  a_r11_collision_kept: assert property (@(posedge clk) disable iff (!rst_n)
    esr_wr |=> hidden_q == $past(incoming));

  a_r10_irq_on_new: assert property (@(posedge clk) disable iff (!rst_n)
    ((|new_bits) && !ent_mask) |=> err_irq);

  a_r10_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|new_bits) || ent_mask) |=> !err_irq);

  a_r7_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && bad_access) |-> reg_rdata == 32'h0);
endmodule

bind intr_err_status intr_err_status_checker u_chk (
  .clk(clk), .rst_n(rst_n), .esr_wr(esr_wr), .incoming(incoming),
  .hidden_q(hidden_q), .esr_q(esr_q), .new_bits(new_bits),
  .ent_mask(ent_mask), .err_irq(err_irq), .reg_rd(reg_rd),
  .bad_access(bad_access), .reg_rdata(reg_rdata)
);

// File: tb/intr_err_status_bench.sv
`timescale 1ns/1ps
module intr_err_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  bus_err = '0;
  logic        send_vec_err = 1'b0;
  logic        err_irq;
  logic [7:0]  err_irq_vec;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intr_err_status u_intr_err_status (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_err(bus_err), .send_vec_err(send_vec_err),
    .err_irq(err_irq), .err_irq_vec(err_irq_vec)
  );

  // {kind(1: strobe), addr, data, expected ESR after snapshot}
  localparam logic [44:0] TBL [0:11] = '{
    {1'b0, 4'd2,  32'h0001_0005, 8'h40}, // R5 masked fixed vec 5
    {1'b0, 4'd3,  32'h0000_0020, 8'h00}, // R5 legal vector
    {1'b0, 4'd4,  32'h0000_0403, 8'h00}, // R5 non-fixed mode
    {1'b0, 4'd5,  32'h0000_000F, 8'h40}, // R5 boundary 15
    {1'b0, 4'd5,  32'h0000_0010, 8'h00}, // R5 boundary 16
    {1'b0, 4'd1,  32'h0001_0000, 8'h40}, // R6 error entry vec 0
    {1'b0, 4'd9,  32'h0000_0055, 8'h80}, // R7 unmapped write
    {1'b0, 4'd15, 32'h0000_0000, 8'h80}, // R7 top offset
    {1'b0, 4'd0,  32'h0000_00FF, 8'h00}, // R2 data ignored
    {1'b1, 4'd0,  32'h0000_001F, 8'h2F}, // R4 R8 all strobes
    {1'b1, 4'd0,  32'h0000_0004, 8'h04}, // R4 send accept
    {1'b1, 4'd0,  32'h0000_0010, 8'h20}  // R4 send vector
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic strobe(input logic [4:0] s);
    @(negedge clk); bus_err = s[3:0]; send_vec_err = s[4];
    @(negedge clk); bus_err = '0; send_vec_err = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'd0, v); chk("R1 esr", v, 32'h0);
    rd(4'd1, v); chk("R1 error entry", v, 32'h0001_0000);
    rd(4'd3, v); chk("R1 table entry", v, 32'h0001_0000);
    chk("R1 irq", {31'b0, err_irq}, 32'h0);
    wr(4'd0, 0); rd(4'd0, v); chk("R1 latch empty", v, 32'h0);

    for (int i = 0; i < 12; i++) begin
      if (TBL[i][44]) strobe(TBL[i][12:8]);
      else            wr(TBL[i][43:40], TBL[i][39:8]);
      wr(4'd0, 0);
      rd(4'd0, v); chk($sformatf("table row %0d", i), v, {24'b0, TBL[i][7:0]});
      wr(4'd0, 0);
    end

    // R9 hidden until write; R3 second write clears
    strobe(5'b00010);
    rd(4'd0, v); chk("R9 not yet visible", v, 32'h0);
    wr(4'd0, 0); rd(4'd0, v); chk("R9 visible after write", v, 32'h02);
    wr(4'd0, 0); rd(4'd0, v); chk("R3 second write zero", v, 32'h0);

    // R12 readback
    wr(4'd4, 32'h0001_0425); rd(4'd4, v); chk("R12 fields", v, 32'h0001_0425);
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, v); chk("R12 spare bits", v, 32'h0001_07FF);

    // R7 unmapped read
    wr(4'd0, 0); wr(4'd0, 0);
    rd(4'd12, v); chk("R7 read zero", v, 32'h0);
    wr(4'd0, 0); rd(4'd0, v); chk("R7 flagged", v, 32'h80);
    wr(4'd0, 0);

    // R10 interrupt
    wr(4'd1, 32'h0000_0033);
    strobe(5'b00001);
    chk("R10 irq raised", {31'b0, err_irq}, 32'h1);
    chk("R10 vector", {24'b0, err_irq_vec}, 32'h33);
    @(negedge clk); chk("R10 one cycle", {31'b0, err_irq}, 32'h0);
    strobe(5'b00001);
    chk("R10 held bit silent", {31'b0, err_irq}, 32'h0);
    wr(4'd1, 32'h0001_0033);
    strobe(5'b00100);
    chk("R10 masked silent", {31'b0, err_irq}, 32'h0);
    wr(4'd0, 0); wr(4'd0, 0);

    // R11 collision with ESR write
    strobe(5'b00001);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 4'd0; bus_err = 4'b0010;
    @(negedge clk); reg_wr = 1'b0; bus_err = '0;
    rd(4'd0, v); chk("R11 old snapshot", v, 32'h01);
    wr(4'd0, 0); rd(4'd0, v); chk("R11 kept for next", v, 32'h02);

    finish_run();
  end
endmodule